// File: doc/BRIEF.md
# Prebiased Soft-Start Sequencer

This block is the clocked start-up controller of a buck converter whose output may already hold charge when the converter is enabled. After enable it keeps both power switches off, so nothing discharges the output, until a comparator reports that the soft-start reference has risen past the feedback voltage. Switching then opens with a single low-side pulse so the bootstrap capacitor is charged, and only from the next cycle are both switches permitted.

A fixed safe-startup window of 4096 clock cycles follows the first pulse. At its end the block picks the steady operating mode once and holds it. In the auto variant it picks skip mode when the inductor zero-current flag is high on that edge, and forced PWM otherwise. In the forced variant it always picks forced PWM. Power-good is qualified by a 48-cycle delay on the feedback-good comparator flag. A 4-bit sink-current-limit code climbs through four staged thresholds over 128 cycles after each enable, so an output charged above its set point is pulled down gently. Dropping enable returns everything to the idle state.

Top module: `pbss_seq`

## Requirements
- R1: From the first clock edge that samples enable high, and until the edge that samples refAboveFb high, hsAllow and lsAllow are both 0.
- R2: On the cycle after the edge that samples refAboveFb high, lsAllow=1, lsFirstPulse=1 and hsAllow=0. On the following cycle hsAllow=1, lsAllow=1 and lsFirstPulse=0, and both permissions stay high while enable stays high.
- R3: pwrGood goes to 1 after the 48th consecutive clock edge that samples fbGood high while enable is high. It is 0 at the 47th edge, and it returns to 0 one edge after fbGood is sampled low.
- R4: If fbGood drops before the 48-edge delay completes, the delay restarts from zero at the next rise of fbGood.
- R5: The safe-startup window lasts 4096 cycles, counted from the first-pulse cycle. modeSkip can change only at the edge that ends the 4096th cycle and is 0 before that edge.
- R6: modeSkip encoding: 1 = skip mode, 0 = forced PWM. At the end of the window, modeSkip = !forceFpwm && ilZero, with both inputs sampled on that edge. With forceFpwm=1 the result is 0 whatever ilZero is.
- R7: sinkCode is 4'h1 for the first 32 cycles after the enable edge, then 4'h3, 4'h7 and 4'hF for 32 cycles each, and it stays at 4'hF after that.
- R8: Once selected, modeSkip holds its value until enable drops. Later changes of ilZero have no effect on it.
- R9: One edge after enable is sampled low, hsAllow, lsAllow, lsFirstPulse, pwrGood and modeSkip are 0 and sinkCode is 4'h1. A new enable restarts the whole sequence.
- R10: While rstN is low, all outputs are 0 except sinkCode, which is 4'h1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Converter enable |
| refAboveFb | input | 1 | Soft-start reference has crossed feedback |
| fbGood | input | 1 | Feedback above 92.5% of set point |
| ilZero | input | 1 | Inductor current has reached zero |
| forceFpwm | input | 1 | Strap: 1 selects the always-forced-PWM variant |
| hsAllow | output | 1 | High-side switch permission |
| lsAllow | output | 1 | Low-side switch permission |
| lsFirstPulse | output | 1 | Request for the first low-side pulse |
| pwrGood | output | 1 | Delayed power-good |
| modeSkip | output | 1 | Operating mode: 1 skip, 0 forced PWM |
| sinkCode | output | 4 | Sink-current-limit DAC code |

## Verification
The hardest situations to reach are the mode decision on the single edge that closes the 4096-cycle window, and a feedback-good drop that lands inside the 48-cycle power-good delay while the window is still running. The stimulus holds ilZero and the strap steady across the whole window, at random or directed values, and checks modeSkip on the cycle before and the cycle after the exit edge. In the same power-up it raises fbGood at a random offset and, in some runs, inserts a one-cycle drop at a random point inside the delay. It then checks power-good exactly 47 and 48 edges after the last rise, and a cycle-level bench model checks sinkCode and pwrGood on every cycle.

// File: rtl/pbss_pkg.sv
package pbss_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_KICK,
    ST_SAFE,
    ST_RUN
  } seqState_e;

  // strobes from the control FSM to the counter datapath
  typedef struct packed {
    logic clrAll;     // enable low: return every counter to zero
    logic rampRun;    // advance the sink-limit ramp
    logic safeRun;    // advance the safe-startup window
    logic latchMode;  // window closes on this edge: capture the mode
    logic pgClr;      // restart the power-good delay
  } seqStrobe_t;

endpackage

// File: rtl/pbss_sat_counter.sv
module pbss_sat_counter #(
  parameter int LIMIT = 15,
  localparam int W = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         atLimit
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              cnt <= '0;
    else if (clr)                           cnt <= '0;
    else if (inc && (cnt != W'(LIMIT)))     cnt <= cnt + 1'b1;
  end

  assign atLimit = (cnt == W'(LIMIT));

endmodule

// File: rtl/pbss_ctrl.sv
module pbss_ctrl
  import pbss_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       refAboveFb,
  input  logic       fbGood,
  input  logic       safeDone,
  output seqStrobe_t strobe,
  output logic       hsAllow,
  output logic       lsAllow,
  output logic       lsFirstPulse
);

  seqState_e state, stateNext;

  always_comb begin
    stateNext = state;
    if (!enable) begin
      stateNext = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: stateNext = ST_HOLD;
        ST_HOLD: if (refAboveFb) stateNext = ST_KICK;
        ST_KICK: stateNext = ST_SAFE;
        ST_SAFE: if (safeDone) stateNext = ST_RUN;
        ST_RUN:  stateNext = ST_RUN;
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.clrAll    = !enable;
    strobe.rampRun   = enable && (state != ST_IDLE);
    strobe.safeRun   = enable && ((state == ST_KICK) || (state == ST_SAFE));
    strobe.latchMode = enable && (state == ST_SAFE) && safeDone;
    strobe.pgClr     = !enable || !fbGood;
  end

  assign lsFirstPulse = (state == ST_KICK);
  assign lsAllow      = (state == ST_KICK) || (state == ST_SAFE) || (state == ST_RUN);
  assign hsAllow      = (state == ST_SAFE) || (state == ST_RUN);

  // R1
  hold_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && (state == ST_HOLD) && !refAboveFb) |=> (!hsAllow && !lsAllow));

  // R2
  kick_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hsAllow) |-> $past(lsFirstPulse));

  // R9
  disable_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!hsAllow && !lsAllow && !lsFirstPulse));

endmodule

// File: rtl/pbss_dpath.sv
module pbss_dpath
  import pbss_pkg::*;
#(
  parameter int SAFE_CYCLES = 4096,
  parameter int PG_DELAY    = 48,
  parameter int RAMP_STEP   = 32,
  parameter int RAMP_STEPS  = 4,
  parameter int CODE_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              fbGood,
  input  logic              ilZero,
  input  logic              forceFpwm,
  output logic              safeDone,
  output logic              pwrGood,
  output logic              modeSkip,
  output logic [CODE_W-1:0] sinkCode
);

  localparam int SAFE_LIMIT = SAFE_CYCLES - 1;
  localparam int RAMP_LIMIT = RAMP_STEP * RAMP_STEPS;
  localparam int SAFE_W     = $clog2(SAFE_LIMIT + 1);
  localparam int PG_W       = $clog2(PG_DELAY + 1);
  localparam int RAMP_W     = $clog2(RAMP_LIMIT + 1);

  logic [SAFE_W-1:0] safeCnt;
  logic [PG_W-1:0]   pgCnt;
  logic [RAMP_W-1:0] rampCnt;
  logic              rampTop;

  pbss_sat_counter #(.LIMIT(SAFE_LIMIT)) safeCtr_i (
    .clk(clk), .rstN(rstN), .clr(strobe.clrAll), .inc(strobe.safeRun),
    .cnt(safeCnt), .atLimit(safeDone));

  pbss_sat_counter #(.LIMIT(PG_DELAY)) pgCtr_i (
    .clk(clk), .rstN(rstN), .clr(strobe.pgClr), .inc(1'b1),
    .cnt(pgCnt), .atLimit(pwrGood));

  pbss_sat_counter #(.LIMIT(RAMP_LIMIT)) rampCtr_i (
    .clk(clk), .rstN(rstN), .clr(strobe.clrAll), .inc(strobe.rampRun),
    .cnt(rampCnt), .atLimit(rampTop));

  // staged threshold: step k drives the lowest k+1 bits high
  always_comb begin
    int stepIdx;
    stepIdx = int'(rampCnt) / RAMP_STEP;
    if (rampTop || (stepIdx > RAMP_STEPS - 1)) stepIdx = RAMP_STEPS - 1;
    sinkCode = CODE_W'((1 << (stepIdx + 1)) - 1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 modeSkip <= 1'b0;
    else if (strobe.clrAll)    modeSkip <= 1'b0;
    else if (strobe.latchMode) modeSkip <= !forceFpwm && ilZero;
  end

  // R3
  pg_needs_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    pwrGood |-> $past(fbGood));

  // R4
  pg_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    !fbGood |=> (pgCnt == '0));

  // R5
  safe_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchMode |-> (safeCnt == SAFE_W'(SAFE_LIMIT)));

  // R6
  forced_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.latchMode && forceFpwm) |=> !modeSkip);

  // R7
  ramp_mono_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rampRun |=> (sinkCode >= $past(sinkCode)));

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.latchMode && !strobe.clrAll) |=> $stable(modeSkip));

endmodule

// File: rtl/pbss_seq.sv
module pbss_seq
  import pbss_pkg::*;
#(
  parameter int SAFE_CYCLES = 4096,
  parameter int PG_DELAY    = 48,
  parameter int RAMP_STEP   = 32,
  parameter int RAMP_STEPS  = 4,
  parameter int CODE_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              refAboveFb,
  input  logic              fbGood,
  input  logic              ilZero,
  input  logic              forceFpwm,
  output logic              hsAllow,
  output logic              lsAllow,
  output logic              lsFirstPulse,
  output logic              pwrGood,
  output logic              modeSkip,
  output logic [CODE_W-1:0] sinkCode
);

  seqStrobe_t strobe;
  logic       safeDone;

  pbss_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .enable(enable), .refAboveFb(refAboveFb),
    .fbGood(fbGood), .safeDone(safeDone), .strobe(strobe),
    .hsAllow(hsAllow), .lsAllow(lsAllow), .lsFirstPulse(lsFirstPulse));

  pbss_dpath #(
    .SAFE_CYCLES(SAFE_CYCLES), .PG_DELAY(PG_DELAY), .RAMP_STEP(RAMP_STEP),
    .RAMP_STEPS(RAMP_STEPS), .CODE_W(CODE_W)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fbGood(fbGood),
    .ilZero(ilZero), .forceFpwm(forceFpwm), .safeDone(safeDone),
    .pwrGood(pwrGood), .modeSkip(modeSkip), .sinkCode(sinkCode));

endmodule

// File: tb/pbss_seq_tb_top.sv
`timescale 1ns/1ps
module pbss_seq_tb_top;

  logic clk = 1'b0;
  logic rstN, enable, refAboveFb, fbGood, ilZero, forceFpwm;
  logic hsAllow, lsAllow, lsFirstPulse, pwrGood, modeSkip;
  logic [3:0] sinkCode;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench model state, derived from the requirements
  int  rampM = 0;
  bit  enSeen = 0;
  int  pgM = 0;

  always #2 clk = ~clk;

  pbss_seq dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .refAboveFb(refAboveFb),
    .fbGood(fbGood), .ilZero(ilZero), .forceFpwm(forceFpwm),
    .hsAllow(hsAllow), .lsAllow(lsAllow), .lsFirstPulse(lsFirstPulse),
    .pwrGood(pwrGood), .modeSkip(modeSkip), .sinkCode(sinkCode));

  function automatic int expCode(int cyc);
    if (cyc < 32) return 1;
    if (cyc < 64) return 3;
    if (cyc < 96) return 7;
    return 15;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: update the model on the edge, then sample at the negedge
  task automatic tick();
    @(posedge clk);
    if (!rstN || !enable) begin
      rampM = 0; enSeen = 0; pgM = 0;
    end else begin
      if (enSeen && rampM < 128) rampM++;
      enSeen = 1;
      if (fbGood) pgM = (pgM < 48) ? pgM + 1 : 48;
      else        pgM = 0;
    end
    @(negedge clk);
    chk("R7 sinkCode", int'(sinkCode), expCode(rampM));
    chk("R3 pwrGood model", int'(pwrGood), (pgM >= 48) ? 1 : 0);
  endtask

  task automatic disableAll();
    enable = 0; tick();
    chk("R9 hsAllow", int'(hsAllow), 0);
    chk("R9 lsAllow", int'(lsAllow), 0);
    chk("R9 lsFirstPulse", int'(lsFirstPulse), 0);
    chk("R9 pwrGood", int'(pwrGood), 0);
    chk("R9 modeSkip", int'(modeSkip), 0);
    chk("R9 sinkCode", int'(sinkCode), 1);
    refAboveFb = 0; fbGood = 0; ilZero = 0;
    tick();
  endtask

  // full power-up; glitch < 0 means no fbGood drop
  task automatic powerUp(int crossDelay, bit forced, bit ilz, int fbRise, int glitch);
    int lastRise;
    forceFpwm = forced; ilZero = ilz; refAboveFb = 0; fbGood = 0;
    enable = 1; tick();
    chk("R1 hsAllow", int'(hsAllow), 0);
    chk("R1 lsAllow", int'(lsAllow), 0);
    for (int i = 0; i < crossDelay; i++) begin
      tick();
      chk("R1 hsAllow hold", int'(hsAllow), 0);
      chk("R1 lsAllow hold", int'(lsAllow), 0);
    end
    refAboveFb = 1; tick();
    chk("R2 lsAllow kick", int'(lsAllow), 1);
    chk("R2 lsFirstPulse", int'(lsFirstPulse), 1);
    chk("R2 hsAllow kick", int'(hsAllow), 0);
    tick();
    chk("R2 hsAllow after", int'(hsAllow), 1);
    chk("R2 lsAllow after", int'(lsAllow), 1);
    chk("R2 lsFirstPulse off", int'(lsFirstPulse), 0);
    lastRise = (glitch < 0) ? fbRise : fbRise + glitch + 1;
    for (int s = 3; s <= 4097; s++) begin
      if (s == fbRise) fbGood = 1;
      if (glitch >= 0 && s == fbRise + glitch) fbGood = 0;
      if (glitch >= 0 && s == fbRise + glitch + 1) fbGood = 1;
      tick();
      if (s == lastRise + 46) chk("R4 pwrGood at 47", int'(pwrGood), 0);
      if (s == lastRise + 47) chk("R3 pwrGood at 48", int'(pwrGood), 1);
      if (s == 4096) chk("R5 modeSkip before exit", int'(modeSkip), 0);
      if (s == 4097) chk("R6 modeSkip at exit", int'(modeSkip), (!forced && ilz) ? 1 : 0);
      if (s == 2000) chk("R2 hsAllow stays", int'(hsAllow & lsAllow), 1);
    end
    ilZero = !ilz;
    repeat (5) tick();
    chk("R8 modeSkip held", int'(modeSkip), (!forced && ilz) ? 1 : 0);
    chk("R7 sinkCode final", int'(sinkCode), 15);
  endtask

  initial begin
    void'($urandom(32'd7719));
    rstN = 0; enable = 0; refAboveFb = 0; fbGood = 0; ilZero = 0; forceFpwm = 0;
    repeat (3) tick();
    chk("R10 hsAllow", int'(hsAllow), 0);
    chk("R10 lsAllow", int'(lsAllow), 0);
    chk("R10 pwrGood", int'(pwrGood), 0);
    chk("R10 modeSkip", int'(modeSkip), 0);
    chk("R10 sinkCode", int'(sinkCode), 1);
    rstN = 1; tick();

    // directed corners
    powerUp(3, 1'b0, 1'b1, 10, -1);   disableAll();
    powerUp(1, 1'b1, 1'b1, 60, 47);   disableAll();
    powerUp(20, 1'b0, 1'b0, 200, 1);  disableAll();

    // abort mid-window with power-good up, then restart
    enable = 1; forceFpwm = 0; ilZero = 1; tick();
    repeat (4) tick();
    refAboveFb = 1; fbGood = 1;
    repeat (300) tick();
    chk("R3 pwrGood before abort", int'(pwrGood), 1);
    disableAll();

    // random power-ups
    for (int n = 0; n < 3; n++) begin
      int cd, fr, gl;
      bit fv, iz;
      cd = 1 + int'($urandom % 40);
      fr = 3 + int'($urandom % 300);
      gl = ($urandom % 2 == 0) ? -1 : 1 + int'($urandom % 46);
      fv = 1'($urandom % 2);
      iz = 1'($urandom % 2);
      powerUp(cd, fv, iz, fr, gl);
      disableAll();
    end

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule